// File: doc/BRIEF.md
# Timer Interrupt Collector and Router

This block sits between a bank of timer channels and the interrupt fabric. Each channel sends a one-clock fire pulse. The block turns that pulse into either a wire interrupt or a memory-write message. Per channel configuration picks one of three outcomes:

- level signalling, where a status bit is latched and holds its line high;
- edge signalling, which gives a one-clock pulse on the line;
- a message write, built from that channel's 64-bit route word.

Software clears latched status by writing ones to the status port.

A legacy routing mode pins timer 0 and timer 1 to two fixed lines, whatever their route fields say. In the same mode the block blocks an external real-time-clock interrupt that would otherwise pass straight through to the second fixed line. Bus decode and the counter are outside this block. It receives the configuration fields as plain inputs.

Top module: `tmr_irq_router`

## Requirements
- R1: After reset, `statusOut` is 0 and `msgValid` is 0. Every `irqLines` bit is 0, except that line `LEGACY_LINE_B` follows `rtcIrqIn` while `legacyMode` is 0.
- R2: A fire on an active channel with `tmrLevel`=1 and `tmrMsgEn`=0 sets its status bit on the next clock edge. The line chosen by its route drives high from that edge and stays high until the bit is cleared.
- R3: A fire on an active channel with `tmrLevel`=0 and `tmrMsgEn`=0 clears its status bit. Its routed line goes high for exactly one clock.
- R4: A status write sets bit i of `stsWrData` to 1 for timer i. A 1 clears that status bit and drops its line. A 0 bit has no effect. A level fire in the same cycle as a clearing write leaves the bit set.
- R5: A channel is active only when both `globalEn` and its `tmrEnable` bit are 1. An inactive channel has its status bit cleared on the next edge, and its fires are ignored.
- R6: The route field of timer i is `tmrRoute[i*LINE_W +: LINE_W]` and holds a line number. With `legacyMode`=1, timer 0 uses line `LEGACY_LINE_A` (0) and timer 1 uses line `LEGACY_LINE_B` (8). All other timers use their route field in both modes.
- R7: With `legacyMode`=0, line 8 carries `rtcIrqIn`. With `legacyMode`=1, that input is blocked. Leaving legacy mode restores line 8 to the current input level.
- R8: A fire on an active channel with `tmrMsgEn`=1 pulses `msgValid` for one clock, starting on the next edge. `msgAddr` then holds bits 63:32 and `msgData` holds bits 31:0 of `msgRoute[i*64 +: 64]`. No line is driven and the status bit is unchanged.
- R9: A 0-to-1 change of a channel's `tmrMsgEn` clears that channel's status bit on the next edge and drops its line.
- R10: When several message fires arrive in the same cycle, the block issues one write per clock, lowest timer index first.
- R11: Sources that drive the same line are OR-combined. The line stays high until every source on it has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fireIn | input | TMR_CNT | One-clock fire pulse per timer |
| globalEn | input | 1 | Global interrupt enable |
| legacyMode | input | 1 | Legacy fixed routing for timers 0 and 1 |
| tmrEnable | input | TMR_CNT | Per-timer interrupt enable |
| tmrLevel | input | TMR_CNT | 1 = level signalling, 0 = edge signalling |
| tmrMsgEn | input | TMR_CNT | 1 = message write replaces line signalling |
| tmrRoute | input | TMR_CNT*LINE_W | Packed per-timer line number |
| msgRoute | input | TMR_CNT*64 | Packed per-timer message word (address high, data low) |
| stsWrEn | input | 1 | Status write strobe |
| stsWrData | input | TMR_CNT | Write-one-to-clear mask |
| rtcIrqIn | input | 1 | External real-time-clock interrupt level |
| irqLines | output | NUM_LINES | Interrupt output lines |
| statusOut | output | TMR_CNT | Latched interrupt status |
| msgValid | output | 1 | Message write request, one clock |
| msgAddr | output | 32 | Message write address |
| msgData | output | 32 | Message write data |

## Verification
The bench looks at how the two legacy overrides interact with the route fields. A design that applied the override to every timer, or to none, would raise the wrong line in the table walk.

It also checks three same-cycle cases:
- A level fire during a clearing write. A design where the clear wins would lose a fresh interrupt.
- Two simultaneous message fires. A design that dropped or reordered a message would show a missing or swapped address.
- Two level sources sharing one line. A design that let one clear release the line would drop it early.

Edge pulses are sampled a second time to catch lines that stick high. The real-time-clock path is toggled through legacy entry and exit to catch a stale line.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int TMR_CNT = 4;
  localparam int MSG_W = 64;

  typedef logic [TMR_CNT-1:0] tmr_mask_t;

  // Strobes from control to datapath, one bit per timer.
  typedef struct packed {
    tmr_mask_t active;    // channel enabled and global enable set
    tmr_mask_t setSts;    // latch status (level fire)
    tmr_mask_t clrSts;    // clear status
    tmr_mask_t fireEdge;  // one-clock line pulse
    tmr_mask_t fireMsg;   // queue a message write
  } irq_strobe_t;
endpackage

// File: rtl/irqr_ctrl.sv
module irqr_ctrl
  import irqr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  tmr_mask_t   fireIn,
  input  logic        globalEn,
  input  tmr_mask_t   tmrEnable,
  input  tmr_mask_t   tmrLevel,
  input  tmr_mask_t   tmrMsgEn,
  input  logic        stsWrEn,
  input  tmr_mask_t   stsWrData,
  output irq_strobe_t strb
);
  tmr_mask_t msgEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) msgEnQ <= '0;
    else       msgEnQ <= tmrMsgEn;
  end

  for (genvar i = 0; i < TMR_CNT; i++) begin : g_tmr
    logic isActive, fireOk, msgRise, wrClr;
    assign isActive = globalEn & tmrEnable[i];
    assign fireOk   = fireIn[i] & isActive;
    assign msgRise  = tmrMsgEn[i] & ~msgEnQ[i];
    assign wrClr    = stsWrEn & stsWrData[i];

    assign strb.active[i]   = isActive;
    assign strb.fireMsg[i]  = fireOk & tmrMsgEn[i];
    assign strb.setSts[i]   = fireOk & ~tmrMsgEn[i] & tmrLevel[i];
    assign strb.fireEdge[i] = fireOk & ~tmrMsgEn[i] & ~tmrLevel[i];
    assign strb.clrSts[i]   = ~isActive | msgRise | wrClr | strb.fireEdge[i];
  end
endmodule

// File: rtl/irqr_dpath.sv
module irqr_dpath
  import irqr_pkg::*;
#(
  parameter int NUM_LINES     = 16,
  parameter int LEGACY_LINE_A = 0,
  parameter int LEGACY_LINE_B = 8,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int IDX_W  = (TMR_CNT > 1) ? $clog2(TMR_CNT) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  irq_strobe_t                strb,
  input  logic                       legacyMode,
  input  tmr_mask_t                  tmrMsgEn,
  input  logic [TMR_CNT*LINE_W-1:0]  tmrRoute,
  input  logic [TMR_CNT*MSG_W-1:0]   msgRoute,
  input  logic                       rtcIrqIn,
  output logic [NUM_LINES-1:0]       irqLines,
  output tmr_mask_t                  statusOut,
  output logic                       msgValid,
  output logic [31:0]                msgAddr,
  output logic [31:0]                msgData
);
  tmr_mask_t stsQ, edgeQ, pendQ, cand, grantOH, srcOn;
  logic [IDX_W-1:0] grantIdx;
  logic [LINE_W-1:0] effRoute [TMR_CNT];

  // status latch and edge pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stsQ  <= '0;
      edgeQ <= '0;
    end else begin
      stsQ  <= (stsQ & ~strb.clrSts) | strb.setSts;
      edgeQ <= strb.fireEdge;
    end
  end
  assign statusOut = stsQ;
  assign srcOn = (stsQ | edgeQ) & ~tmrMsgEn;

  // per-timer effective line
  for (genvar i = 0; i < TMR_CNT; i++) begin : g_route
    if (i == 0) begin : g_leg0
      assign effRoute[i] = legacyMode ? LINE_W'(LEGACY_LINE_A) : tmrRoute[i*LINE_W +: LINE_W];
    end else if (i == 1) begin : g_leg1
      assign effRoute[i] = legacyMode ? LINE_W'(LEGACY_LINE_B) : tmrRoute[i*LINE_W +: LINE_W];
    end else begin : g_norm
      assign effRoute[i] = tmrRoute[i*LINE_W +: LINE_W];
    end
  end

  always_comb begin
    irqLines = '0;
    for (int i = 0; i < TMR_CNT; i++) begin
      if (srcOn[i]) irqLines[effRoute[i]] = 1'b1;
    end
    if (!legacyMode && rtcIrqIn) irqLines[LEGACY_LINE_B] = 1'b1;
  end

  // message queue: lowest index first, one per clock
  assign cand = (pendQ & strb.active) | strb.fireMsg;

  always_comb begin
    logic found;
    found    = 1'b0;
    grantOH  = '0;
    grantIdx = '0;
    for (int i = 0; i < TMR_CNT; i++) begin
      if (cand[i] && !found) begin
        found      = 1'b1;
        grantOH[i] = 1'b1;
        grantIdx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= '0;
      msgValid <= 1'b0;
      msgAddr  <= '0;
      msgData  <= '0;
    end else begin
      pendQ    <= cand & ~grantOH;
      msgValid <= |cand;
      if (|cand) begin
        msgAddr <= msgRoute[grantIdx*MSG_W + 32 +: 32];
        msgData <= msgRoute[grantIdx*MSG_W +: 32];
      end
    end
  end

  // R10
  msg_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pendQ & strb.active) > 0 |=> msgValid);
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import irqr_pkg::*;
#(
  parameter int NUM_LINES     = 16,
  parameter int LEGACY_LINE_A = 0,
  parameter int LEGACY_LINE_B = 8,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [TMR_CNT-1:0]        fireIn,
  input  logic                      globalEn,
  input  logic                      legacyMode,
  input  logic [TMR_CNT-1:0]        tmrEnable,
  input  logic [TMR_CNT-1:0]        tmrLevel,
  input  logic [TMR_CNT-1:0]        tmrMsgEn,
  input  logic [TMR_CNT*LINE_W-1:0] tmrRoute,
  input  logic [TMR_CNT*MSG_W-1:0]  msgRoute,
  input  logic                      stsWrEn,
  input  logic [TMR_CNT-1:0]        stsWrData,
  input  logic                      rtcIrqIn,
  output logic [NUM_LINES-1:0]      irqLines,
  output logic [TMR_CNT-1:0]        statusOut,
  output logic                      msgValid,
  output logic [31:0]               msgAddr,
  output logic [31:0]               msgData
);
  irq_strobe_t strb;

  irqr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fireIn(fireIn), .globalEn(globalEn),
    .tmrEnable(tmrEnable), .tmrLevel(tmrLevel), .tmrMsgEn(tmrMsgEn),
    .stsWrEn(stsWrEn), .stsWrData(stsWrData), .strb(strb)
  );

  irqr_dpath #(
    .NUM_LINES(NUM_LINES), .LEGACY_LINE_A(LEGACY_LINE_A), .LEGACY_LINE_B(LEGACY_LINE_B)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .legacyMode(legacyMode),
    .tmrMsgEn(tmrMsgEn), .tmrRoute(tmrRoute), .msgRoute(msgRoute),
    .rtcIrqIn(rtcIrqIn), .irqLines(irqLines), .statusOut(statusOut),
    .msgValid(msgValid), .msgAddr(msgAddr), .msgData(msgData)
  );

  for (genvar i = 0; i < TMR_CNT; i++) begin : g_chk
    // R5
    disabled_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!globalEn || !tmrEnable[i]) |=> !statusOut[i]);
    // R4
    w1c_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stsWrEn && stsWrData[i] && !fireIn[i]) |=> !statusOut[i]);
    // R2
    level_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statusOut[i]) |-> $past(fireIn[i] && tmrLevel[i] && !tmrMsgEn[i]));
  end

  // R7
  rtc_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!legacyMode && rtcIrqIn) |-> irqLines[LEGACY_LINE_B]);
endmodule

// File: tb/tb_tmr_irq_router.sv
`timescale 1ns/1ps
module tb_tmr_irq_router;
  localparam int NT = 4;
  localparam int NL = 16;
  localparam int LW = 4;

  logic clk = 0;
  logic rstN = 0;
  logic [NT-1:0] fireIn = '0, tmrEnable = '1, tmrLevel = '0, tmrMsgEn = '0, stsWrData = '0;
  logic globalEn = 1, legacyMode = 0, stsWrEn = 0, rtcIrqIn = 0;
  logic [NT*LW-1:0] tmrRoute = '0;
  logic [NT*64-1:0] msgRoute = '0;
  logic [NL-1:0] irqLines;
  logic [NT-1:0] statusOut;
  logic msgValid;
  logic [31:0] msgAddr, msgData;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_irq_router dut (
    .clk(clk), .rstN(rstN), .fireIn(fireIn), .globalEn(globalEn), .legacyMode(legacyMode),
    .tmrEnable(tmrEnable), .tmrLevel(tmrLevel), .tmrMsgEn(tmrMsgEn), .tmrRoute(tmrRoute),
    .msgRoute(msgRoute), .stsWrEn(stsWrEn), .stsWrData(stsWrData), .rtcIrqIn(rtcIrqIn),
    .irqLines(irqLines), .statusOut(statusOut), .msgValid(msgValid),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  // {timer[1:0], level, route[3:0], legacy, expLine[3:0]}
  localparam logic [11:0] VEC [6] = '{
    {2'd0, 1'b1, 4'd2,  1'b0, 4'd2},
    {2'd1, 1'b0, 4'd7,  1'b0, 4'd7},
    {2'd0, 1'b1, 4'd5,  1'b1, 4'd0},
    {2'd1, 1'b1, 4'd5,  1'b1, 4'd8},
    {2'd2, 1'b0, 4'd5,  1'b1, 4'd5},
    {2'd3, 1'b1, 4'd15, 1'b0, 4'd15}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic fire(logic [NT-1:0] m);
    fireIn = m; tick(); fireIn = '0;
  endtask

  task automatic w1c(logic [NT-1:0] m);
    stsWrEn = 1; stsWrData = m; tick(); stsWrEn = 0; stsWrData = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    chk("R1 status", statusOut, 0);
    chk("R1 lines", irqLines, 0);
    chk("R1 msgValid", msgValid, 0);

    // table walk: R2 R3 R6
    for (int v = 0; v < 6; v++) begin
      logic [1:0] t; logic lv; logic [3:0] rt; logic lg; logic [3:0] ex;
      {t, lv, rt, lg, ex} = VEC[v];
      tmrLevel = '0; tmrLevel[t] = lv;
      tmrRoute[t*LW +: LW] = rt;
      legacyMode = lg;
      tick();
      fire(NT'(1) << t);
      chk(lv ? "R2 R6 line" : "R3 R6 line", irqLines, NL'(1) << ex);
      chk(lv ? "R2 status set" : "R3 status clear", statusOut, lv ? NT'(1) << t : 0);
      tick();
      chk(lv ? "R2 line held" : "R3 pulse one clock", irqLines, lv ? NL'(1) << ex : 0);
      w1c(NT'(1) << t);
      chk("R4 cleared line", irqLines, 0);
      chk("R4 cleared status", statusOut, 0);
    end
    legacyMode = 0;

    // R4 write 0 no effect, fire beats clear
    tmrLevel = 4'b0100; tmrRoute[2*LW +: LW] = 4'd5;
    fire(4'b0100);
    w1c(4'b0000);
    chk("R4 write zero status", statusOut, 4'b0100);
    chk("R4 write zero line", irqLines, 16'h0020);
    fireIn = 4'b0100; stsWrEn = 1; stsWrData = 4'b0100; tick();
    fireIn = '0; stsWrEn = 0; stsWrData = '0;
    chk("R4 fire wins over clear", statusOut, 4'b0100);

    // R5 global disable clears
    globalEn = 0; tick();
    chk("R5 global off status", statusOut, 0);
    chk("R5 global off line", irqLines, 0);
    globalEn = 1; tmrEnable[2] = 0;
    fire(4'b0100);
    chk("R5 disabled fire ignored", statusOut, 0);
    chk("R5 disabled fire line", irqLines, 0);
    tmrEnable = '1;

    // R7 rtc pass-through
    rtcIrqIn = 1; tick();
    chk("R7 pass", irqLines, 16'h0100);
    legacyMode = 1; tick();
    chk("R7 masked in legacy", irqLines, 0);
    legacyMode = 0; tick();
    chk("R7 restored", irqLines, 16'h0100);
    rtcIrqIn = 0; tick();
    chk("R7 follows low", irqLines, 0);

    // R8 message write
    tmrLevel = '1; tmrMsgEn = 4'b1000;
    msgRoute[3*64 +: 64] = 64'h1234_5678_9ABC_DEF0;
    tick();
    fire(4'b1000);
    chk("R8 valid", msgValid, 1);
    chk("R8 addr", msgAddr, 32'h1234_5678);
    chk("R8 data", msgData, 32'h9ABC_DEF0);
    chk("R8 no line", irqLines, 0);
    chk("R8 status unchanged", statusOut, 0);
    tick();
    chk("R8 one clock", msgValid, 0);
    tmrMsgEn = '0;

    // R9 message enable rise clears pending
    tmrRoute[0 +: LW] = 4'd3;
    fire(4'b0001);
    chk("R9 pre status", statusOut, 4'b0001);
    tmrMsgEn = 4'b0001; tick();
    chk("R9 status cleared", statusOut, 0);
    chk("R9 line dropped", irqLines, 0);
    tmrMsgEn = '0;

    // R10 simultaneous messages
    tmrMsgEn = 4'b1010;
    msgRoute[1*64 +: 64] = 64'hAAAA_0001_BBBB_0001;
    msgRoute[3*64 +: 64] = 64'hAAAA_0003_BBBB_0003;
    tick();
    fire(4'b1010);
    chk("R10 first valid", msgValid, 1);
    chk("R10 first addr", msgAddr, 32'hAAAA_0001);
    tick();
    chk("R10 second valid", msgValid, 1);
    chk("R10 second addr", msgAddr, 32'hAAAA_0003);
    chk("R10 second data", msgData, 32'hBBBB_0003);
    tick();
    chk("R10 drained", msgValid, 0);
    tmrMsgEn = '0;

    // R11 OR-combine on a shared line
    tmrRoute[0 +: LW] = 4'd6; tmrRoute[2*LW +: LW] = 4'd6;
    fire(4'b0101);
    chk("R11 both on", irqLines, 16'h0040);
    w1c(4'b0001);
    chk("R11 held by other", irqLines, 16'h0040);
    w1c(4'b0100);
    chk("R11 released", irqLines, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule